// File: doc/BRIEF.md
# Per-Block Flash Lock Manager

This block holds the protection record of every erase block in a top-boot flash array. The array has a row of small parameter blocks at the top of the word address space and larger main blocks below it. A command decoder upstream hands it one strobe per bus write, carrying the command code and the word address. A two-write sequence changes the record of one block: a setup code, then a confirm code that selects lock, unlock or lock-down.

Each block is in one of three states: unlocked, locked or locked-down. A locked-down block counts as locked in hardware and in software. While the write-protect pin is low it cannot be unlocked. While the pin is high the lock-down is overridden, so commands may unlock or relock the block. Only reset clears the lock-down. A query port takes any word address. One cycle later it returns whether a program or erase at that address is allowed, and the 2-bit lock status word that an identifier read at that address would return.

Top module: `blk_lock_mgr`

## Requirements
- R1: While rst is high and on the first cycle after it, both outputs read zero. After reset every block is locked: write-allowed is 0 everywhere and the status word at offset 0x02 of every block reads 2'b01.
- R2: With the default parameters, blocks 0 to 14 are 32 Kword main blocks starting at word 0x00000. Blocks 15 to 22 are 4 Kword parameter blocks starting at 0x78000. The first and last word of each block decode to that block, and a command acts only on the block it addresses.
- R3: A lock change is code 0x60 followed by a confirm: 0x01 locks, 0xD0 unlocks and 0x2F locks down. The confirm write's address selects the block. Cycles with cmd_valid low between the two writes do not cancel the setup.
- R4: A confirm code with no setup before it has no effect. After 0x60, any other code (including 0x60 again) is a sequence error. It leaves every record unchanged and cancels the setup, so a following confirm code does nothing.
- R5: While wp_n is 0, an unlock of a locked-down block is ignored and its status reads 2'b11.
- R6: While wp_n is 1, a locked-down block may be unlocked: status reads 2'b10 and writes are allowed. When wp_n returns to 0, the block reads 2'b11 with writes blocked. A lock command sets it back to 2'b11.
- R7: Only reset clears lock-down: after reset a previously locked-down block reads 2'b01.
- R8: Status word encoding is bit 0 = effective lock, bit 1 = lock-down. It is returned only when the query address is at offset 0x02 within its block; any other offset returns 2'b00. Write-allowed is 1 exactly when the effective lock bit is 0.
- R9: The outputs are registered. They reflect q_addr and wp_n sampled at the previous clock edge. A confirm write accepted at one edge shows in the outputs from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also power-up |
| cmd_valid | input | 1 | One bus write command this cycle |
| cmd_code | input | 8 | Command code of the write |
| cmd_addr | input | ADDR_W | Word address of the write |
| wp_n | input | 1 | Write-protect pin, low = lock-down enforced |
| q_addr | input | ADDR_W | Word address to query |
| q_wr_ok | output | 1 | Program/erase allowed at queried address |
| q_lock | output | 2 | Lock status word for queried address |

## Verification
The assertions assume that cmd_valid and cmd_code are clean known values at each edge, and that wp_n changes only between edges. The bench drives all inputs at the falling edge, so every input is stable around each rising edge. The status-related properties take wp_n one edge back, because the outputs sample it there. The bench therefore changes wp_n only between probes and never in the same cycle as a lookup it checks.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  localparam logic [7:0] CODE_SETUP  = 8'h60;
  localparam logic [7:0] CODE_LOCK   = 8'h01;
  localparam logic [7:0] CODE_UNLOCK = 8'hD0;
  localparam logic [7:0] CODE_LDOWN  = 8'h2F;

  typedef enum logic [1:0] {OP_LOCK, OP_UNLOCK, OP_LDOWN} lk_op_e;

  // record: bit 1 = lock-down, bit 0 = lock
  typedef logic [1:0] lk_rec_t;

  function automatic int blk_count(int aw, int pblks, int paw, int maw);
    return pblks + (((1 << aw) - (pblks << paw)) >> maw);
  endfunction
endpackage

// File: rtl/blk_lock_decode.sv
module blk_lock_decode #(
  parameter int ADDR_W   = 19,
  parameter int PAR_BLKS = 8,
  parameter int PAR_AW   = 12,
  parameter int MAIN_AW  = 15,
  parameter int IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              off2
);
  localparam int unsigned SPAN      = 1 << ADDR_W;
  localparam int unsigned PAR_SPAN  = PAR_BLKS << PAR_AW;
  localparam int unsigned MAIN_BLKS = (SPAN - PAR_SPAN) >> MAIN_AW;
  localparam logic [ADDR_W-1:0] PAR_BASE = ADDR_W'(SPAN - PAR_SPAN);

  logic              in_par;
  logic [ADDR_W-1:0] par_rel;

  always_comb begin
    in_par  = (addr >= PAR_BASE);
    par_rel = addr - PAR_BASE;
    if (in_par) begin
      idx  = IDX_W'(MAIN_BLKS) + IDX_W'(par_rel >> PAR_AW);
      off2 = (addr[PAR_AW-1:0] == PAR_AW'(2));
    end else begin
      idx  = IDX_W'(addr >> MAIN_AW);
      off2 = (addr[MAIN_AW-1:0] == MAIN_AW'(2));
    end
  end
endmodule

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
  import blk_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       armed,
  output logic       upd_en,
  output lk_op_e     upd_op
);
  always_comb begin
    upd_en = 1'b0;
    upd_op = OP_LOCK;
    if (cmd_valid && armed) begin
      case (cmd_code)
        CODE_LOCK:   begin upd_en = 1'b1; upd_op = OP_LOCK;   end
        CODE_UNLOCK: begin upd_en = 1'b1; upd_op = OP_UNLOCK; end
        CODE_LDOWN:  begin upd_en = 1'b1; upd_op = OP_LDOWN;  end
        default:     begin upd_en = 1'b0; upd_op = OP_LOCK;   end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (cmd_valid)
      armed <= !armed && (cmd_code == CODE_SETUP);
  end
endmodule

// File: rtl/blk_lock_store.sv
module blk_lock_store
  import blk_lock_pkg::*;
#(
  parameter int NBLK  = 23,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  lk_op_e           upd_op,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             wp_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_off2,
  output logic             rd_wr_ok,
  output logic [1:0]       rd_lock
);
  lk_rec_t rec [NBLK];
  lk_rec_t cur;
  logic    eff_lk;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBLK; i++) rec[i] <= 2'b01;
    end else if (upd_en) begin
      case (upd_op)
        OP_LOCK:   rec[upd_idx][0] <= 1'b1;
        OP_UNLOCK: if (!(rec[upd_idx][1] && !wp_n)) rec[upd_idx][0] <= 1'b0;
        OP_LDOWN:  rec[upd_idx] <= 2'b11;
        default:   rec[upd_idx] <= rec[upd_idx];
      endcase
    end
  end

  always_comb begin
    cur    = rec[rd_idx];
    eff_lk = cur[0] | (cur[1] & !wp_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_wr_ok <= 1'b0;
      rd_lock  <= 2'b00;
    end else begin
      rd_wr_ok <= !eff_lk;
      rd_lock  <= rd_off2 ? {cur[1], eff_lk} : 2'b00;
    end
  end
endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import blk_lock_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int PAR_BLKS = 8,
  parameter int PAR_AW   = 12,
  parameter int MAIN_AW  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_wr_ok,
  output logic [1:0]        q_lock
);
  localparam int NBLK  = blk_count(ADDR_W, PAR_BLKS, PAR_AW, MAIN_AW);
  localparam int IDX_W = $clog2(NBLK);

  logic [IDX_W-1:0] dec_idx [2];
  logic             dec_off2 [2];
  logic             seq_armed;
  logic             upd_en;
  lk_op_e           upd_op;

  // port 0 decodes the command address, port 1 the query address
  for (genvar g = 0; g < 2; g++) begin : g_dec
    blk_lock_decode #(
      .ADDR_W(ADDR_W), .PAR_BLKS(PAR_BLKS), .PAR_AW(PAR_AW),
      .MAIN_AW(MAIN_AW), .IDX_W(IDX_W)
    ) u_dec (
      .addr (g == 0 ? cmd_addr : q_addr),
      .idx  (dec_idx[g]),
      .off2 (dec_off2[g])
    );
  end

  blk_lock_seq u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .armed(seq_armed), .upd_en(upd_en), .upd_op(upd_op)
  );

  blk_lock_store #(.NBLK(NBLK), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_op(upd_op),
    .upd_idx(dec_idx[0]), .wp_n(wp_n), .rd_idx(dec_idx[1]),
    .rd_off2(dec_off2[1]), .rd_wr_ok(q_wr_ok), .rd_lock(q_lock)
  );
endmodule

// File: rtl/blk_lock_mgr_chk.sv
module blk_lock_mgr_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       wp_n,
  input logic       armed,
  input logic       q_wr_ok,
  input logic [1:0] q_lock
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (q_lock == 2'b00 && !q_wr_ok));

  // R5
  ldown_held_chk: assert property (@(posedge clk) disable iff (rst)
    (q_lock[1] && !$past(wp_n)) |-> q_lock[0]);

  // R8
  lock_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    q_lock[0] |-> !q_wr_ok);

  // R3
  setup_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !armed && cmd_code == 8'h60) |=> armed);

  // R4
  second_write_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && armed) |=> !armed);

  // R3
  idle_keeps_arm_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(armed));
endmodule

bind blk_lock_mgr blk_lock_mgr_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .wp_n(wp_n), .armed(seq_armed), .q_wr_ok(q_wr_ok), .q_lock(q_lock)
);

// File: tb/blk_lock_mgr_test.sv
module blk_lock_mgr_test;
  localparam int AW    = 19;
  localparam int NMAIN = 15;
  localparam int NB    = 23;
  localparam int PBASE = 'h78000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_code = 8'h00;
  logic [AW-1:0] cmd_addr = '0;
  logic          wp_n = 1'b0;
  logic [AW-1:0] q_addr = '0;
  logic          q_wr_ok;
  logic [1:0]    q_lock;

  always #5 clk = ~clk;

  blk_lock_mgr uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .wp_n(wp_n), .q_addr(q_addr),
    .q_wr_ok(q_wr_ok), .q_lock(q_lock)
  );

  int checks = 0;
  int fails  = 0;
  bit mld [NB];
  bit mlk [NB];
  bit marm = 1'b0;

  function automatic int base_of(int i);
    return (i < NMAIN) ? i * 32768 : PBASE + (i - NMAIN) * 4096;
  endfunction
  function automatic int size_of(int i);
    return (i < NMAIN) ? 32768 : 4096;
  endfunction
  function automatic int blk_of(int a);
    return (a >= PBASE) ? NMAIN + (a - PBASE) / 4096 : a / 32768;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin mld[i] = 1'b0; mlk[i] = 1'b1; end
    marm = 1'b0;
  endtask

  task automatic do_reset(string tag);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk({tag, " reset wr_ok"}, int'(q_wr_ok), 0);
    chk({tag, " reset status"}, int'(q_lock), 0);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic wr(logic [7:0] code, int a);
    int b;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_addr = a[AW-1:0];
    if (!marm) marm = (code == 8'h60);
    else begin
      marm = 1'b0;
      b = blk_of(a);
      case (code)
        8'h01: mlk[b] = 1'b1;
        8'hD0: if (!(mld[b] && !wp_n)) mlk[b] = 1'b0;
        8'h2F: begin mld[b] = 1'b1; mlk[b] = 1'b1; end
        default: ;
      endcase
    end
    @(negedge clk) cmd_valid = 1'b0;
  endtask

  task automatic probe(int a, string tag);
    int b; bit eff; int exl;
    @(negedge clk) q_addr = a[AW-1:0];
    @(negedge clk);
    b   = blk_of(a);
    eff = mlk[b] | (mld[b] & !wp_n);
    exl = ((a - base_of(b)) == 2) ? int'({mld[b], eff}) : 0;
    chk($sformatf("%s wr_ok @%h", tag, a), int'(q_wr_ok), int'(!eff));
    chk($sformatf("%s status @%h", tag, a), int'(q_lock), exl);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NB; i++) begin
      probe(base_of(i), tag);
      probe(base_of(i) + 2, tag);
      probe(base_of(i) + size_of(i) - 1, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset("R1");
    check_all("R1 all locked after reset");

    // R2 R3: unlock even blocks, confirm at last word of block
    for (int i = 0; i < NB; i += 2) begin
      wr(8'h60, base_of(i));
      wr(8'hD0, base_of(i) + size_of(i) - 1);
    end
    check_all("R2 R3 even blocks unlocked");

    // R4: lone confirm, bad second code, double setup
    wr(8'hD0, base_of(1));
    probe(base_of(1) + 2, "R4 lone confirm");
    wr(8'h60, base_of(1)); wr(8'hFF, base_of(1)); wr(8'hD0, base_of(1));
    probe(base_of(1) + 2, "R4 bad code then confirm");
    wr(8'h60, base_of(17)); wr(8'h60, base_of(17)); wr(8'hD0, base_of(17));
    probe(base_of(17) + 2, "R4 double setup");

    // R3: setup survives idle cycles
    wr(8'h60, base_of(0));
    repeat (5) @(negedge clk);
    wr(8'h01, base_of(0) + 100);
    probe(base_of(0) + 2, "R3 relock after idle gap");

    // R5: lock-down then unlock with wp_n low
    wr(8'h60, base_of(3));  wr(8'h2F, base_of(3));
    wr(8'h60, base_of(20)); wr(8'h2F, base_of(20));
    probe(base_of(3) + 2, "R5 lockdown main");
    probe(base_of(20) + 2, "R5 lockdown param");
    wr(8'h60, base_of(3)); wr(8'hD0, base_of(3));
    wr(8'h60, base_of(20)); wr(8'hD0, base_of(20));
    probe(base_of(3) + 2, "R5 unlock ignored");
    probe(base_of(20) + 5, "R5 unlock ignored wr_ok");

    // R6: wp_n high override
    @(negedge clk) wp_n = 1'b1;
    probe(base_of(3) + 2, "R6 still locked");
    wr(8'h60, base_of(3)); wr(8'hD0, base_of(3));
    probe(base_of(3) + 2, "R6 unlocked under override");
    @(negedge clk) wp_n = 1'b0;
    probe(base_of(3) + 2, "R6 pin low relocks");
    @(negedge clk) wp_n = 1'b1;
    wr(8'h60, base_of(3)); wr(8'h01, base_of(3));
    probe(base_of(3) + 2, "R6 lock under override");
    wr(8'h60, base_of(20)); wr(8'hD0, base_of(20));

    // R8: other offsets read zero status
    for (int i = 0; i < NB; i += 5) begin
      probe(base_of(i) + 1, "R8 offset 1");
      probe(base_of(i) + 3, "R8 offset 3");
    end

    // R9: output latency for address and for a confirm write
    probe(base_of(2) + 2, "R9 setup");
    @(negedge clk) q_addr = AW'(base_of(1) + 2);
    #1;
    chk("R9 old address held before edge", int'(q_wr_ok), 1);
    @(negedge clk);
    chk("R9 new address after edge", int'(q_wr_ok), 0);
    wr(8'h60, base_of(2));
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h01; cmd_addr = AW'(base_of(2));
    q_addr = AW'(base_of(2) + 2);
    @(negedge clk);
    cmd_valid = 1'b0; marm = 1'b0; mlk[2] = 1'b1;
    chk("R9 confirm not yet visible", int'(q_lock), 0);
    @(negedge clk);
    chk("R9 confirm visible next edge", int'(q_lock), 1);

    // R7: reset clears lock-down
    do_reset("R7");
    probe(base_of(3) + 2, "R7 lockdown cleared main");
    probe(base_of(20) + 2, "R7 lockdown cleared param");

    // R2: decode boundaries with odd blocks unlocked
    for (int i = 1; i < NB; i += 2) begin
      wr(8'h60, base_of(i)); wr(8'hD0, base_of(i));
    end
    check_all("R2 decode odd pattern");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule